// File: doc/BRIEF.md
# Fast Page Mode DRAM Strobe Sequencer

This block turns requests from a synchronous host into the strobe sequence of an asynchronous DRAM. The DRAM takes its address over one shared, multiplexed bus and has a one-bit data path. Each request carries a write flag, a read-modify-write flag, a 22-bit address and one data bit. The controller splits the address into an 11-bit row (upper bits) and an 11-bit column (lower bits). It first presents the row and lowers the row strobe. It then presents the column and lowers the column strobe. Every strobe output is registered. Every interval is a parameter counted in clock cycles.

After a column access the row is left open. A later request to the same row needs only a new column-strobe cycle. A request to another row closes the row, precharges and opens the new row. The row is also closed when the row-active timer reaches a limit derived from the maximum row-active time, or when the `hold` input is raised. `hold` also blocks new activations, which lets an outside arbiter, for example a refresh engine, take the DRAM.

A plain write is issued as an early write: write enable falls one cycle before the column strobe. A read-modify-write first reads the cell while write enable is high. It then pulses write enable low while the column strobe is still low, and the new bit is stored in the same cell.

Top module: `fpm_dram_ctrl`

States:
- `S_IDLE`: no row is open.
- `S_RAS`: the row strobe is low; the controller waits out the row-to-column delay.
- `S_CADDR`: the column address, write enable and data are set up with the column strobe still high.
- `S_COL`: the column strobe is low; a read is sampled in the last cycle.
- `S_RMW`: the write-enable pulse of a read-modify-write.
- `S_CPRE`: column precharge.
- `S_OPEN`: the row is open and the controller waits for a request.
- `S_CLOSE`: the row strobe is held low until the minimum row-active time is met.
- `S_PRE`: row precharge.

Transitions:
- `S_IDLE` to `S_RAS` when a request is accepted.
- `S_RAS` to `S_CADDR` to `S_COL`.
- `S_COL` to `S_RMW` (read-modify-write) or to `S_CPRE`.
- `S_RMW` to `S_CPRE`, then `S_CPRE` to `S_OPEN`.
- `S_OPEN` to `S_CADDR` on a page hit.
- `S_OPEN` to `S_CLOSE` on a miss, on expiry or on `hold`.
- `S_CLOSE` to `S_PRE`.
- `S_PRE` to `S_RAS` (a request is pending and `hold` is low) or to `S_IDLE`.

## Requirements
- R1: During and after reset `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1 and `rsp_done` is 0.
- R2: When `dram_ras_n` falls, `dram_a` carries `req_addr[21:11]`. When `dram_cas_n` falls, `dram_a` carries `req_addr[10:0]`. The first column strobe of a row falls at least T_RCD cycles after the row strobe. The column strobe is low only while the row strobe is low.
- R3: A read (`req_we`=0) keeps `dram_we_n` high at the falling column strobe. It returns the sampled `dram_q` on `rsp_rdata` in the cycle in which `rsp_done` is 1. `rsp_done` is high for exactly one cycle per request.
- R4: A write with `req_rmw`=0 is an early write. `dram_we_n` is low in the cycle before `dram_cas_n` falls and stays low while the column strobe falls. `dram_d` carries `req_wdata`.
- R5: A write with `req_rmw`=1 keeps `dram_we_n` high at the falling column strobe. It returns the old cell value on `rsp_rdata`. It then pulses `dram_we_n` low while `dram_cas_n` is low, so that `req_wdata` is stored.
- R6: A request to the row that is open produces a column cycle without a new falling edge of `dram_ras_n`.
- R7: A request to another row raises `dram_ras_n`, precharges, and opens the new row with a single new falling edge.
- R8: Each low period of `dram_ras_n` lasts at least T_RAS_MIN and fewer than T_RAS_MAX cycles. An idle open row is closed without any request.
- R9: `dram_ras_n` stays high at least T_RP cycles between two activations.
- R10: While `hold` is 1, no request is accepted, an open row is closed and `dram_ras_n` stays high. A request held across `hold` completes after `hold` drops.
- R11: Within an open row, `dram_cas_n` is high at least T_CP cycles between two falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold | input | 1 | Arbiter hold: blocks activations and closes the row |
| req | input | 1 | Request, held by the host until `rsp_done` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_rmw | input | 1 | With `req_we`: read-modify-write instead of early write |
| req_addr | input | 22 | Row in [21:11], column in [10:0] |
| req_wdata | input | 1 | Write data |
| rsp_rdata | output | 1 | Read data (old value for read-modify-write) |
| rsp_done | output | 1 | One-cycle completion pulse |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_a | output | 11 | Multiplexed row/column address |
| dram_d | output | 1 | Data to the DRAM |
| dram_q | input | 1 | Data from the DRAM |

## Verification
The bench builds the controller with short intervals: T_RCD, T_CAS, T_WP and T_CP at 2 cycles, T_RP at 3 and T_RAS_MIN at 6. With T_RAS_MAX lowered to 100 cycles, the row-expiry close can be reached in a directed test, and an eight-access page burst still fits inside one activation. A behavioural DRAM model in the bench decodes the strobes. It measures every row-active, precharge, row-to-column and column-precharge interval against these values, so that timing slips show up as well as data errors.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RAS,
        S_CADDR,
        S_COL,
        S_RMW,
        S_CPRE,
        S_OPEN,
        S_CLOSE,
        S_PRE
    } fpm_state_e;

    function automatic int fpm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_phase_timer.sv
module fpm_phase_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fpm_row_tracker.sv
module fpm_row_tracker #(
    parameter int ROW_W     = 11,
    parameter int RC_W      = 13,
    parameter int T_RAS_MIN = 25,
    parameter int LIMIT     = 2480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             rel,
    input  logic [ROW_W-1:0] act_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             hit,
    output logic             min_met,
    output logic             expired
);
    localparam logic [RC_W-1:0] MIN_C = RC_W'(T_RAS_MIN);
    localparam logic [RC_W-1:0] LIM_C = RC_W'(LIMIT);

    logic [ROW_W-1:0] row_q;
    logic             vld;
    logic [RC_W-1:0]  rcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            vld   <= 1'b0;
            rcnt  <= '0;
        end else if (act) begin
            row_q <= act_row;
            vld   <= 1'b1;
            rcnt  <= RC_W'(1);
        end else if (rel) begin
            vld   <= 1'b0;
            rcnt  <= '0;
        end else if (vld && rcnt != '1) begin
            rcnt  <= rcnt + 1'b1;
        end
    end

    assign hit     = vld && (cmp_row == row_q);
    assign min_met = (rcnt >= MIN_C);
    assign expired = (rcnt >= LIM_C);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int COL_W     = 11,
    parameter int T_RCD     = 5,
    parameter int T_CAS     = 5,
    parameter int T_WP      = 4,
    parameter int T_CP      = 3,
    parameter int T_RP      = 18,
    parameter int T_RAS_MIN = 25,
    parameter int T_RAS_MAX = 2500
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                hold,
    input  logic                                req,
    input  logic                                req_we,
    input  logic                                req_rmw,
    input  logic [ROW_W+COL_W-1:0]              req_addr,
    input  logic                                req_wdata,
    output logic                                rsp_rdata,
    output logic                                rsp_done,
    output logic                                dram_ras_n,
    output logic                                dram_cas_n,
    output logic                                dram_we_n,
    output logic [fpm_max(ROW_W, COL_W)-1:0]    dram_a,
    output logic                                dram_d,
    input  logic                                dram_q
);
    localparam int AW     = fpm_max(ROW_W, COL_W);
    localparam int ADW    = ROW_W + COL_W;
    localparam int PH_MAX = fpm_max(fpm_max(T_RCD, T_CAS), fpm_max(fpm_max(T_WP, T_CP), T_RP));
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int RC_W   = $clog2(T_RAS_MAX + 1) + 1;
    localparam int LIMIT  = T_RAS_MAX - (T_CAS + T_WP + T_CP + 3);

    fpm_state_e st, st_nx;

    logic [ADW-1:0] q_addr, a_nx;
    logic           q_we, q_rmw, q_wd, pend;
    logic           we_nx, rmw_nx, wd_nx;
    logic           acc, set_pend;
    logic           ph_zero, ph_load;
    logic [PH_W-1:0] ph_val;
    logic           hit, min_met, expired;
    logic           act, rel;

    // request acceptance and next-cycle request fields
    always_comb begin
        acc      = 1'b0;
        set_pend = 1'b0;
        st_nx    = st;
        unique case (st)
            S_IDLE: begin
                if (req && !hold) begin
                    acc   = 1'b1;
                    st_nx = S_RAS;
                end
            end
            S_RAS:   if (ph_zero) st_nx = S_CADDR;
            S_CADDR: st_nx = S_COL;
            S_COL: begin
                if (ph_zero) st_nx = q_rmw ? S_RMW : S_CPRE;
            end
            S_RMW:   if (ph_zero) st_nx = S_CPRE;
            S_CPRE:  if (ph_zero) st_nx = S_OPEN;
            S_OPEN: begin
                if (hold) begin
                    st_nx = S_CLOSE;
                end else if (req) begin
                    acc = 1'b1;
                    if (hit && !expired) begin
                        st_nx = S_CADDR;
                    end else begin
                        set_pend = 1'b1;
                        st_nx    = S_CLOSE;
                    end
                end else if (expired) begin
                    st_nx = S_CLOSE;
                end
            end
            S_CLOSE: if (min_met) st_nx = S_PRE;
            S_PRE: begin
                if (ph_zero) begin
                    if (!pend)      st_nx = S_IDLE;
                    else if (!hold) st_nx = S_RAS;
                end
            end
            default: st_nx = S_IDLE;
        endcase
    end

    assign a_nx   = acc ? req_addr  : q_addr;
    assign we_nx  = acc ? req_we    : q_we;
    assign rmw_nx = acc ? (req_we && req_rmw) : q_rmw;
    assign wd_nx  = acc ? req_wdata : q_wd;

    // phase lengths
    always_comb begin
        unique case (st_nx)
            S_RAS:   ph_val = PH_W'(T_RCD - 1);
            S_COL:   ph_val = PH_W'(T_CAS - 1);
            S_RMW:   ph_val = PH_W'(T_WP - 1);
            S_CPRE:  ph_val = PH_W'(T_CP - 1);
            S_PRE:   ph_val = PH_W'(T_RP - 1);
            default: ph_val = '0;
        endcase
    end

    assign ph_load = (st_nx != st);
    assign act     = (st_nx == S_RAS) && (st != S_RAS);
    assign rel     = (st_nx == S_PRE) && (st != S_PRE);

    fpm_phase_timer #(.W(PH_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    fpm_row_tracker #(
        .ROW_W     (ROW_W),
        .RC_W      (RC_W),
        .T_RAS_MIN (T_RAS_MIN),
        .LIMIT     (LIMIT)
    ) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .rel     (rel),
        .act_row (a_nx[ADW-1:COL_W]),
        .cmp_row (req_addr[ADW-1:COL_W]),
        .hit     (hit),
        .min_met (min_met),
        .expired (expired)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // request holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr <= '0;
            q_we   <= 1'b0;
            q_rmw  <= 1'b0;
            q_wd   <= 1'b0;
            pend   <= 1'b0;
        end else begin
            q_addr <= a_nx;
            q_we   <= we_nx;
            q_rmw  <= rmw_nx;
            q_wd   <= wd_nx;
            if (set_pend)        pend <= 1'b1;
            else if (st_nx == S_RAS) pend <= 1'b0;
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_a     <= '0;
            dram_d     <= 1'b0;
            rsp_done   <= 1'b0;
            rsp_rdata  <= 1'b0;
        end else begin
            rsp_done <= ((st == S_COL) && ph_zero && !q_rmw) ||
                        ((st == S_RMW) && ph_zero);
            if ((st == S_COL) && ph_zero && !(q_we && !q_rmw))
                rsp_rdata <= dram_q;
            unique case (st_nx)
                S_IDLE, S_PRE: begin
                    dram_ras_n <= 1'b1;
                    dram_cas_n <= 1'b1;
                    dram_we_n  <= 1'b1;
                end
                S_RAS: begin
                    dram_ras_n <= 1'b0;
                    dram_cas_n <= 1'b1;
                    dram_we_n  <= 1'b1;
                    dram_a     <= AW'(a_nx[ADW-1:COL_W]);
                end
                S_CADDR, S_COL: begin
                    dram_ras_n <= 1'b0;
                    dram_cas_n <= (st_nx == S_CADDR);
                    dram_we_n  <= !(we_nx && !rmw_nx);
                    dram_a     <= AW'(a_nx[COL_W-1:0]);
                    dram_d     <= wd_nx;
                end
                S_RMW: begin
                    dram_ras_n <= 1'b0;
                    dram_cas_n <= 1'b0;
                    dram_we_n  <= 1'b0;
                    dram_d     <= wd_nx;
                end
                S_CPRE, S_OPEN, S_CLOSE: begin
                    dram_ras_n <= 1'b0;
                    dram_cas_n <= 1'b1;
                    dram_we_n  <= 1'b1;
                end
                default: begin
                    dram_ras_n <= 1'b1;
                    dram_cas_n <= 1'b1;
                    dram_we_n  <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
    parameter int T_RAS_MIN = 25,
    parameter int T_RAS_MAX = 2500
) (
    input logic clk,
    input logic rst_n,
    input logic hold,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic done
);
    int lo_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)     lo_cnt <= 0;
        else if (ras_n) lo_cnt <= 0;
        else            lo_cnt <= lo_cnt + 1;
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);                                                   // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                      // R3
    AST_EARLY_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> ($past(we_n) == 1'b0));                   // R4
    AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (lo_cnt >= T_RAS_MIN));                              // R8
    AST_RAS_MAX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (lo_cnt < T_RAS_MAX));                                     // R8
    AST_HOLD_KEEPS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && ras_n) |=> ras_n);                                           // R10
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
    .T_RAS_MIN (T_RAS_MIN),
    .T_RAS_MAX (T_RAS_MAX)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold),
    .ras_n (dram_ras_n),
    .cas_n (dram_cas_n),
    .we_n  (dram_we_n),
    .done  (rsp_done)
);

// File: tb/fpm_dram_ctrl_tb.sv
module fpm_dram_ctrl_tb;
    localparam int T_RCD     = 2;
    localparam int T_CAS     = 2;
    localparam int T_WP      = 2;
    localparam int T_CP      = 2;
    localparam int T_RP      = 3;
    localparam int T_RAS_MIN = 6;
    localparam int T_RAS_MAX = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold = 1'b0, req = 1'b0, req_we = 1'b0, req_rmw = 1'b0, req_wdata = 1'b0;
    logic [21:0] req_addr = '0;
    logic        rsp_rdata, rsp_done;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_d;
    logic [10:0] dram_a;
    logic        dq = 1'b0;

    always #2 clk = ~clk;

    fpm_dram_ctrl #(
        .T_RCD (T_RCD), .T_CAS (T_CAS), .T_WP (T_WP), .T_CP (T_CP),
        .T_RP (T_RP), .T_RAS_MIN (T_RAS_MIN), .T_RAS_MAX (T_RAS_MAX)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .hold (hold), .req (req),
        .req_we (req_we), .req_rmw (req_rmw), .req_addr (req_addr),
        .req_wdata (req_wdata), .rsp_rdata (rsp_rdata), .rsp_done (rsp_done),
        .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n),
        .dram_a (dram_a), .dram_d (dram_d), .dram_q (dq)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- DRAM model and strobe monitor ----------------
    logic        mem [0:255];
    logic [10:0] exp_row = '0, exp_col = '0;
    logic [3:0]  row_l = '0;
    logic        p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, first_cas = 1'b0;
    int ras_falls = 0, ew_cnt = 0, rmw_cnt = 0;
    int ras_lo = 0, ras_hi = 1000, cas_hi = 0, since_ras = 0;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 1'b0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            // row strobe
            if (p_ras && !dram_ras_n) begin
                ras_falls++;
                row_l = dram_a[3:0];
                chk(dram_a == exp_row, "R2 row address at row strobe", int'(dram_a), int'(exp_row));
                chk(ras_hi >= T_RP, "R9 row precharge cycles", ras_hi, T_RP);
                since_ras = 0;
                ras_lo = 1;
                first_cas = 1'b1;
            end else if (!p_ras && dram_ras_n) begin
                chk(ras_lo >= T_RAS_MIN && ras_lo <= T_RAS_MAX, "R8 row active cycles", ras_lo, T_RAS_MIN);
                ras_hi = 1;
            end else if (!dram_ras_n) begin
                ras_lo++;
                since_ras++;
            end else begin
                ras_hi++;
            end
            // column strobe
            if (p_cas && !dram_cas_n) begin
                chk(dram_a == exp_col, "R2 column address at column strobe", int'(dram_a), int'(exp_col));
                if (first_cas)
                    chk(since_ras >= T_RCD, "R2 row-to-column cycles", since_ras, T_RCD);
                else
                    chk(cas_hi >= T_CP, "R11 column precharge cycles", cas_hi, T_CP);
                first_cas = 1'b0;
                if (!dram_we_n) begin
                    chk(p_we == 1'b0, "R4 write enable before column strobe", int'(p_we), 0);
                    mem[{row_l, dram_a[3:0]}] = dram_d;
                    ew_cnt++;
                end else begin
                    dq <= mem[{row_l, dram_a[3:0]}];
                end
                exp_col = dram_a;
            end else if (!p_cas && dram_cas_n) begin
                dq <= 1'b0;
                cas_hi = 1;
            end else if (dram_cas_n) begin
                cas_hi++;
            end
            if (p_we && !dram_we_n && !dram_cas_n && !p_cas) begin
                mem[{row_l, exp_col[3:0]}] = dram_d;
                rmw_cnt++;
            end
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
            p_we  = dram_we_n;
        end
    end

    // ---------------- host access ----------------
    task automatic access(input bit w, input bit r, input int row, input int col,
                          input bit d, output bit q);
        int n = 0;
        exp_row   = 11'(row);
        exp_col   = 11'(col);
        req       = 1'b1;
        req_we    = w;
        req_rmw   = r;
        req_addr  = {11'(row), 11'(col)};
        req_wdata = d;
        do begin
            @(negedge clk);
            n++;
        end while (!rsp_done && n < 500);
        req = 1'b0;
        q   = rsp_rdata;
        if (!rsp_done) chk(1'b0, "R3 completion pulse", 0, 1);
    endtask

    task automatic t_reset();
        chk(dram_ras_n == 1'b1, "R1 row strobe in reset", int'(dram_ras_n), 1);
        chk(dram_cas_n == 1'b1, "R1 column strobe in reset", int'(dram_cas_n), 1);
        chk(dram_we_n == 1'b1, "R1 write enable in reset", int'(dram_we_n), 1);
        chk(rsp_done == 1'b0, "R1 done in reset", int'(rsp_done), 0);
    endtask

    task automatic t_basic();
        bit q;
        int f;
        int e = ew_cnt;
        access(1, 0, 3, 5, 1'b1, q);
        access(1, 0, 7, 2, 1'b1, q);
        chk(ew_cnt == e + 2, "R4 early writes seen", ew_cnt - e, 2);
        f = ras_falls;
        access(0, 0, 3, 5, 1'b0, q);
        chk(q == 1'b1, "R3 read of written cell", int'(q), 1);
        chk(ras_falls == f + 1, "R7 miss reopens row once", ras_falls - f, 1);
        f = ras_falls;
        access(0, 0, 3, 6, 1'b0, q);
        chk(q == 1'b0, "R3 read of untouched cell", int'(q), 0);
        chk(ras_falls == f, "R6 hit keeps row open", ras_falls - f, 0);
        chk(dram_ras_n == 1'b0, "R6 row still open after hit", int'(dram_ras_n), 0);
    endtask

    task automatic t_page();
        bit q;
        int f = ras_falls;
        logic [3:0] pat = 4'b1101;
        for (int c = 0; c < 4; c++) access(1, 0, 9, c, pat[c], q);
        for (int c = 0; c < 4; c++) begin
            access(0, 0, 9, c, 1'b0, q);
            chk(q == pat[c], "R6 page burst read-back", int'(q), int'(pat[c]));
        end
        chk(ras_falls == f + 1, "R6 one activation per burst", ras_falls - f, 1);
    endtask

    task automatic t_rmw();
        bit q;
        int r = rmw_cnt;
        int e = ew_cnt;
        access(1, 1, 9, 0, 1'b0, q);
        chk(q == 1'b1, "R5 old value returned", int'(q), 1);
        chk(rmw_cnt == r + 1, "R5 write pulse under column strobe", rmw_cnt - r, 1);
        chk(ew_cnt == e, "R5 no early write", ew_cnt - e, 0);
        access(0, 0, 9, 0, 1'b0, q);
        chk(q == 1'b0, "R5 new value stored", int'(q), 0);
    endtask

    task automatic t_expiry();
        repeat (T_RAS_MAX + 20) @(negedge clk);
        chk(dram_ras_n == 1'b1, "R8 idle row closed by timer", int'(dram_ras_n), 1);
    endtask

    task automatic t_hold();
        bit q;
        int f;
        int n = 0;
        bit seen = 1'b0;
        access(0, 0, 3, 5, 1'b0, q);
        hold = 1'b1;
        repeat (30) @(negedge clk);
        chk(dram_ras_n == 1'b1, "R10 hold closes open row", int'(dram_ras_n), 1);
        f = ras_falls;
        exp_row  = 11'd7;
        exp_col  = 11'd2;
        req_we   = 1'b0;
        req_rmw  = 1'b0;
        req_addr = {11'd7, 11'd2};
        req      = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (rsp_done) seen = 1'b1;
        end
        chk(seen == 1'b0, "R10 no completion during hold", int'(seen), 0);
        chk(ras_falls == f, "R10 no activation during hold", ras_falls - f, 0);
        hold = 1'b0;
        do begin
            @(negedge clk);
            n++;
        end while (!rsp_done && n < 500);
        req = 1'b0;
        chk(rsp_done == 1'b1, "R10 held request completes", int'(rsp_done), 1);
        chk(rsp_rdata == 1'b1, "R10 held read data", int'(rsp_rdata), 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_page();
        t_rmw();
        t_expiry();
        t_hold();
        repeat (40) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule